// File: doc/BRIEF.md
# Two-Stage Watchdog Supervisor Timer

This block supervises software by counting system clock cycles. A two-bit interval select picks one of four power-of-two timeout lengths. When the chosen interval runs out, a sticky timeout flag is set. If the interrupt enable is high, an interrupt request is raised as well. A second stage then runs a fixed grace window. If software has not restarted the timer by the end of that window, and the reset enable is high, the block emits a one-cycle system reset pulse and sets a sticky reset-cause flag.

The interrupt stage and the reset stage have separate enables. Software may use either one, both, or neither. When both enables are low, the timer is idle and both counters are held cleared. After an enable goes high, a fixed start delay passes before counting begins. Software keeps the timer alive with a single-cycle restart strobe, which clears the interval count and cancels any pending reset.

Top module: `wdog_supervisor`

## Requirements
- R1: After the synchronous reset `rst`, the outputs `tmo_flag_o`, `irq_req_o`, `wd_reset_o` and `wd_cause_o` are all 0.
- R2: Interval select value s gives a timeout of 2^(BASE_LOG2 + STEP_LOG2*s) cycles. With the defaults (12 and 3) the values 0, 1, 2 and 3 give 2^12, 2^15, 2^18 and 2^21 cycles.
- R2 (timing): Call the first rising edge that samples an enable high edge 1. Then `tmo_flag_o` rises at edge START_DLY + 1 + 2^(BASE_LOG2 + STEP_LOG2*s). START_DLY is 2 by default.
- R3: While `irq_enable_i` and `reset_enable_i` are both 0, the timer does not advance and the flag never sets.
- R4: A restart strobe sampled while counting clears the count. The flag then rises exactly 2^(...) edges after the edge that sampled the strobe.
- R5: `irq_req_o` is 1 only while `tmo_flag_o` is 1 and `irq_enable_i` was 1 at the previous edge. With `irq_enable_i` low, the flag still sets but no request is raised.
- R6: `tmo_flag_o` stays set until `flag_clear_i` is sampled high. Disabling the timer does not clear it. A timeout in the same cycle as a clear wins.
- R7: GRACE cycles after the timeout edge (512 by default), `wd_reset_o` is high for exactly one cycle. This happens only if `reset_enable_i` is 1.
- R8: A restart strobe during the grace window cancels the pending reset, and counting starts again from zero.
- R9: `wd_cause_o` is set with every reset pulse and stays set until `rst`.
- R10: After the grace window ends, the watchdog restarts from its cleared state. The next timeout comes START_DLY + 2^(...) edges after the edge that ended the grace window.
- R11: Dropping both enables in the middle of a count clears the progress. After the enables return, the full delay plus interval is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_sel_i | input | SEL_W | Timeout interval select |
| irq_enable_i | input | 1 | Enables the interrupt stage |
| reset_enable_i | input | 1 | Enables the reset stage |
| restart_i | input | 1 | Restart strobe from software |
| flag_clear_i | input | 1 | Clears the timeout flag |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_req_o | output | 1 | Interrupt request |
| wd_reset_o | output | 1 | One-cycle system reset pulse |
| wd_cause_o | output | 1 | Sticky flag that a watchdog reset occurred |

## Verification
The main timeout path is run with all four interval selects and a small base exponent. The four measured edge counts separate a wrong exponent step from an off-by-one in the start delay.

The same path is then run in several ways:
- with a restart strobe part way through, to show the count really clears;
- with the enables dropped and raised again, to show a disable clears the count where a pause would not;
- with the reset stage only, where the reset pulse position and the restart delay are each counted edge by edge;
- with a strobe inside the grace window, to show the pending reset is cancelled rather than merely delayed.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_START = 2'd1,
    PH_COUNT = 2'd2,
    PH_GRACE = 2'd3
  } wd_phase_e;
endpackage

// File: rtl/wdog_start_delay.sv
module wdog_start_delay #(
  parameter int START_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int DW = (START_DLY > 1) ? $clog2(START_DLY) : 1;

  logic [DW-1:0] dly_q;

  assign done = (dly_q == DW'(START_DLY - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      dly_q <= '0;
    else if (run && !done)
      dly_q <= dly_q + 1'b1;
  end
endmodule

// File: rtl/wdog_interval_cnt.sv
module wdog_interval_cnt #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [SEL_W-1:0] sel,
  output logic             expired
);
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CNT_W   = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term [NUM_SEL];

  // terminal count per select value: 2^(BASE+STEP*i) - 1
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_term
    localparam int SH = CNT_W - (BASE_LOG2 + STEP_LOG2 * i);
    assign term[i] = ONES >> SH;
  end

  // >= keeps a select lowered mid-count from overrunning
  assign expired = (cnt_q >= term[sel]);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc)
      cnt_q <= cnt_q + 1'b1;
  end

  // R4: a clear always lands the counter on zero next cycle
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_grace_cnt.sv
module wdog_grace_cnt #(
  parameter int GRACE = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int GW = (GRACE > 1) ? $clog2(GRACE) : 1;

  logic [GW-1:0] g_q;

  assign done = (g_q == GW'(GRACE - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      g_q <= '0;
    else if (inc && !done)
      g_q <= g_q + 1'b1;
  end

  // R7: the grace count holds when neither cleared nor advancing
  a_r7_grace_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(g_q));
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 3,
  parameter int GRACE     = 512,
  parameter int START_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] interval_sel_i,
  input  logic             irq_enable_i,
  input  logic             reset_enable_i,
  input  logic             restart_i,
  input  logic             flag_clear_i,
  output logic             tmo_flag_o,
  output logic             irq_req_o,
  output logic             wd_reset_o,
  output logic             wd_cause_o
);
  import wdog_pkg::*;

  wd_phase_e phase_q, phase_n;
  logic en_any, expired, g_done, dly_done;
  logic timeout, grace_end, flag_n, pulse_n;
  logic ival_clr, ival_inc, g_clr, g_inc, dly_clr, dly_run;

  assign en_any = irq_enable_i | reset_enable_i;

  // next-phase selection; restart has priority over expiry
  always_comb begin
    phase_n = phase_q;
    if (!en_any) begin
      phase_n = PH_OFF;
    end else begin
      unique case (phase_q)
        PH_OFF:   phase_n = PH_START;
        PH_START: phase_n = dly_done ? PH_COUNT : PH_START;
        PH_COUNT: begin
          if (restart_i)    phase_n = PH_COUNT;
          else if (expired) phase_n = PH_GRACE;
        end
        PH_GRACE: begin
          if (restart_i)    phase_n = PH_COUNT;
          else if (g_done)  phase_n = PH_START;
        end
        default:            phase_n = PH_OFF;
      endcase
    end
  end

  assign timeout   = en_any && (phase_q == PH_COUNT) && expired && !restart_i;
  assign grace_end = en_any && (phase_q == PH_GRACE) && g_done && !restart_i;

  assign ival_clr = (phase_n != PH_COUNT) || restart_i;
  assign ival_inc = (phase_q == PH_COUNT);
  assign g_clr    = (phase_n != PH_GRACE);
  assign g_inc    = (phase_q == PH_GRACE);
  assign dly_clr  = (phase_n != PH_START);
  assign dly_run  = (phase_q == PH_START);

  assign flag_n  = timeout ? 1'b1 : (flag_clear_i ? 1'b0 : tmo_flag_o);
  assign pulse_n = grace_end && reset_enable_i;

  wdog_start_delay #(.START_DLY(START_DLY)) u_dly (
    .clk(clk), .rst(rst), .clr(dly_clr), .run(dly_run), .done(dly_done)
  );

  wdog_interval_cnt #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_ival (
    .clk(clk), .rst(rst), .clr(ival_clr), .inc(ival_inc),
    .sel(interval_sel_i), .expired(expired)
  );

  wdog_grace_cnt #(.GRACE(GRACE)) u_grace (
    .clk(clk), .rst(rst), .clr(g_clr), .inc(g_inc), .done(g_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_OFF;
      tmo_flag_o <= 1'b0;
      irq_req_o  <= 1'b0;
      wd_reset_o <= 1'b0;
      wd_cause_o <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      tmo_flag_o <= flag_n;
      irq_req_o  <= flag_n & irq_enable_i;
      wd_reset_o <= pulse_n;
      wd_cause_o <= wd_cause_o | pulse_n;
    end
  end

  // R7: reset output is a single-cycle pulse
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wd_reset_o |=> !wd_reset_o);

  // R7: a pulse needs the reset stage enabled
  a_r7_pulse_enabled: assert property (@(posedge clk) disable iff (rst)
    wd_reset_o |-> $past(reset_enable_i));

  // R9: cause flag never drops without reset
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (rst)
    wd_cause_o |=> wd_cause_o);

  // R3: both enables low parks the timer
  a_r3_parked_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_any |=> (phase_q == PH_OFF));

  // R5: a request implies the interrupt stage was enabled
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ($past(irq_enable_i) && tmo_flag_o));

  // R6: flag held unless cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag_o && !flag_clear_i) |=> tmo_flag_o);

  // R8: restart inside grace cancels the reset
  a_r8_restart_cancels: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_GRACE && restart_i && en_any) |=>
      (!wd_reset_o && phase_q == PH_COUNT));
endmodule

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb_top;
  localparam int SEL_W = 2;
  localparam int BASE  = 6;
  localparam int STEP  = 2;
  localparam int GR    = 512;
  localparam int DLY   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic irq_en = 1'b0, rst_en = 1'b0, restart = 1'b0, fclr = 1'b0;
  logic flag, irq, wdrst, cause;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wdog_supervisor #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE), .STEP_LOG2(STEP),
    .GRACE(GR), .START_DLY(DLY)
  ) dut_i (
    .clk(clk), .rst(rst), .interval_sel_i(sel), .irq_enable_i(irq_en),
    .reset_enable_i(rst_en), .restart_i(restart), .flag_clear_i(fclr),
    .tmo_flag_o(flag), .irq_req_o(irq), .wd_reset_o(wdrst), .wd_cause_o(cause)
  );

  function automatic int ival(input int s);
    return 1 << (BASE + STEP * s);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic count_to_flag(input int maxn, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!flag && n < maxn);
  endtask

  task automatic quiesce();
    irq_en = 0; rst_en = 0; restart = 0; fclr = 1;
    tick(); tick();
    fclr = 0;
  endtask

  task automatic t_reset();
    check("R1", "flag after reset", int'(flag), 0);
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "reset pulse after reset", int'(wdrst), 0);
    check("R1", "cause after reset", int'(cause), 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    sel = 0;
    repeat (300) begin
      tick();
      if (flag) seen++;
    end
    check("R3", "flag cycles while disabled", seen, 0);
  endtask

  task automatic t_interval(input int s);
    int n;
    quiesce();
    sel = SEL_W'(s);
    irq_en = 1;
    count_to_flag(ival(s) + 100, n);
    check("R2", $sformatf("edges to timeout sel=%0d", s), n, ival(s) + DLY + 1);
    check("R5", "irq with enable", int'(irq), 1);
  endtask

  task automatic t_restart();
    int n;
    quiesce();
    sel = 0;
    irq_en = 1;
    repeat (40) tick();
    check("R4", "no flag before restart", int'(flag), 0);
    restart = 1;
    tick();
    restart = 0;
    count_to_flag(ival(0) + 100, n);
    check("R4", "edges after restart", n, ival(0));
  endtask

  task automatic t_sticky();
    quiesce();
    sel = 0;
    irq_en = 1;
    repeat (ival(0) + DLY + 1) tick();
    check("R6", "flag set", int'(flag), 1);
    irq_en = 0;
    repeat (20) tick();
    check("R6", "flag kept after disable", int'(flag), 1);
    check("R5", "irq dropped with enable", int'(irq), 0);
    fclr = 1;
    tick();
    fclr = 0;
    check("R6", "flag after clear", int'(flag), 0);
  endtask

  task automatic t_disable_mid();
    int n;
    quiesce();
    sel = 1;
    irq_en = 1;
    repeat (200) tick();
    irq_en = 0;
    repeat (5) tick();
    irq_en = 1;
    count_to_flag(ival(1) + 100, n);
    check("R11", "edges after re-enable", n, ival(1) + DLY + 1);
  endtask

  task automatic t_grace_restart();
    int n;
    int pulses = 0;
    quiesce();
    sel = 0;
    irq_en = 1;
    rst_en = 1;
    count_to_flag(ival(0) + 100, n);
    check("R2", "timeout with both stages", n, ival(0) + DLY + 1);
    repeat (100) tick();
    restart = 1;
    tick();
    restart = 0;
    repeat (500) begin
      tick();
      if (wdrst) pulses++;
    end
    check("R8", "pulses after grace restart", pulses, 0);
    check("R8", "cause after cancel", int'(cause), 0);
  endtask

  task automatic t_reset_path();
    int n;
    int early = 0;
    quiesce();
    sel = 0;
    rst_en = 1;
    count_to_flag(ival(0) + 100, n);
    check("R2", "timeout reset-only", n, ival(0) + DLY + 1);
    check("R5", "no irq when disabled", int'(irq), 0);
    for (int k = 1; k < GR; k++) begin
      tick();
      if (wdrst) early++;
    end
    check("R7", "pulses before grace end", early, 0);
    tick();
    check("R7", "pulse at grace end", int'(wdrst), 1);
    check("R9", "cause set", int'(cause), 1);
    tick();
    check("R7", "pulse one cycle", int'(wdrst), 0);
    fclr = 1;
    tick();
    fclr = 0;
    check("R6", "flag cleared", int'(flag), 0);
    count_to_flag(ival(0) + 100, n);
    check("R10", "edges to next timeout", n, GR + DLY + ival(0) - (GR + 2));
    check("R9", "cause still set", int'(cause), 1);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_disabled();
    for (int s = 0; s < 4; s++) t_interval(s);
    t_restart();
    t_sticky();
    t_disable_mid();
    t_grace_restart();
    t_reset_path();
    report();
  end
endmodule